// File: doc/BRIEF.md
# Region Cacheability Attribute Register File

This block keeps one small attribute word for every 16 MB region of a 32-bit logical address space, which gives 256 regions. Each word says whether its region may be held in a cache and whether a read-ahead engine may fetch from it. Software sets the words through a 32-bit register port, addressed by byte offset. The cache and prefetch engines ask about any bus address on a separate lookup port, and they get the two attribute bits back in the same cycle.

The lowest sixteen regions map internal memory. Their words are fixed as cacheable and cannot be changed. Every other word comes out of reset with both attributes clear. A write is stored at the next clock edge. A read, and a lookup, always show the value stored at that moment.

Top module: `rattr_regfile`

## Requirements
- R1: The space is split into 256 regions of 16 MB; the lookup selects region number addr[31:24].
- R2: In each attribute word, bit 0 is the cacheable flag and bit 3 is the prefetchable flag; the lookup outputs carry those two bits of the selected region.
- R3: Every bit of a read word other than bits 0 and 3 reads as 0, whatever value was written.
- R4: Regions 0 to 15 are read-only: a write to them is ignored, and they always read 0x00000001 (cacheable, not prefetchable).
- R5: The word of region k sits at byte offset 4*k on a 10-bit offset; offset bits [1:0] are ignored, so offset 0x30 is region 12 and 0x3FC is region 255.
- R6: After reset, every writable region (16 to 255) reads 0x00000000.
- R7: A write with cfg_we high is stored at the next rising clock edge; cfg_rdata shows the stored word of the addressed region combinationally.
- R8: The lookup is combinational and always agrees with the stored word of the region it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the register port |
| cfg_off | input | 10 | Byte offset of the addressed word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed word |
| lk_addr | input | 32 | Bus address to classify |
| lk_cacheable | output | 1 | Region of lk_addr may be cached |
| lk_prefetch | output | 1 | Region of lk_addr may be prefetched |

## Verification
The bench builds the block with its default parameters: 256 regions and 16 fixed ones. With these values the border between region 15 and region 16 can be tested, so the bench checks that a write on the last read-only word is dropped and a write on the first writable word is stored. The top offset 0x3FC and an address in 0xFF region test the last entry. Unaligned offsets and addresses with random-looking low bits test that only the region-index bits choose the entry.

// File: rtl/rattr_pkg.sv
package rattr_pkg;

  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned CACHE_B  = 0;
  localparam int unsigned PREF_B   = 3;

  typedef struct packed {
    logic pref;
    logic cache;
  } attr_t;

  // Region index from a bus address: the top IDX_W bits.
  function automatic logic [7:0] region_of_addr(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: 8];
  endfunction

  // Region index from a byte offset: word number, low two bits dropped.
  function automatic logic [7:0] region_of_off(input logic [9:0] off);
    return off[9:2];
  endfunction

  // Build the visible register word from an attribute pair.
  function automatic logic [WORD_W-1:0] word_of_attr(input attr_t at);
    logic [WORD_W-1:0] w;
    w          = '0;
    w[CACHE_B] = at.cache;
    w[PREF_B]  = at.pref;
    return w;
  endfunction

  // Extract the attribute pair from a written word.
  function automatic attr_t attr_of_word(input logic [WORD_W-1:0] w);
    attr_t at;
    at.cache = w[CACHE_B];
    at.pref  = w[PREF_B];
    return at;
  endfunction

endpackage

// File: rtl/rattr_decode.sv
module rattr_decode #(
  parameter int unsigned NREG = 256,
  parameter int unsigned NFIX = 16,
  localparam int unsigned IW  = $clog2(NREG),
  localparam int unsigned OW  = IW + 2
) (
  input  logic          we,
  input  logic [OW-1:0] off,
  output logic [IW-1:0] idx,
  output logic          wr_fixed,
  output logic          wr_accept
);
  always_comb begin
    idx       = off[OW-1:2];
    wr_fixed  = we && (32'(idx) < NFIX);
    wr_accept = we && (32'(idx) >= NFIX);
  end
endmodule

// File: rtl/rattr_store.sv
module rattr_store
  import rattr_pkg::*;
#(
  parameter int unsigned NREG = 256,
  parameter int unsigned NFIX = 16,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_accept,
  input  logic [IW-1:0]    wr_idx,
  input  attr_t            wr_attr,
  output attr_t [NREG-1:0] attr_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g < NFIX) begin : g_fixed
      assign attr_q[g] = '{pref: 1'b0, cache: 1'b1};
    end else begin : g_rw
      attr_t q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= '0;
        else if (wr_accept && (wr_idx == IW'(g)))
          q <= wr_attr;
      end
      assign attr_q[g] = q;
    end
  end
endmodule

// File: rtl/rattr_lookup.sv
module rattr_lookup
  import rattr_pkg::*;
#(
  parameter int unsigned NREG = 256,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  attr_t [NREG-1:0] attr_q,
  input  logic  [IW-1:0]   sel,
  output attr_t            sel_attr
);
  assign sel_attr = attr_q[sel];
endmodule

// File: rtl/rattr_regfile.sv
module rattr_regfile
  import rattr_pkg::*;
#(
  parameter int unsigned NREG = 256,
  parameter int unsigned NFIX = 16,
  localparam int unsigned IW  = $clog2(NREG),
  localparam int unsigned OW  = IW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [OW-1:0]     cfg_off,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_cacheable,
  output logic              lk_prefetch
);
  // Named internal events for the checker.
  logic [IW-1:0]    cfg_idx;
  logic             wr_fixed;
  logic             wr_accept;
  attr_t            wr_attr;
  attr_t [NREG-1:0] attr_q;
  attr_t            rd_attr;
  attr_t            lk_attr;
  logic [IW-1:0]    lk_idx;

  assign wr_attr = attr_of_word(cfg_wdata);
  assign lk_idx  = lk_addr[ADDR_W-1 -: IW];

  rattr_decode #(.NREG(NREG), .NFIX(NFIX)) u_dec (
    .we(cfg_we), .off(cfg_off), .idx(cfg_idx),
    .wr_fixed(wr_fixed), .wr_accept(wr_accept)
  );

  rattr_store #(.NREG(NREG), .NFIX(NFIX)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_accept(wr_accept),
    .wr_idx(cfg_idx), .wr_attr(wr_attr), .attr_q(attr_q)
  );

  rattr_lookup #(.NREG(NREG)) u_rd (
    .attr_q(attr_q), .sel(cfg_idx), .sel_attr(rd_attr)
  );

  rattr_lookup #(.NREG(NREG)) u_lk (
    .attr_q(attr_q), .sel(lk_idx), .sel_attr(lk_attr)
  );

  assign cfg_rdata    = word_of_attr(rd_attr);
  assign lk_cacheable = lk_attr.cache;
  assign lk_prefetch  = lk_attr.pref;
endmodule

// File: rtl/rattr_chk.sv
module rattr_chk
  import rattr_pkg::*;
#(
  parameter int unsigned NREG = 256,
  parameter int unsigned NFIX = 16,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] cfg_wdata,
  input logic [WORD_W-1:0] cfg_rdata,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_cacheable,
  input logic              lk_prefetch,
  input logic [IW-1:0]     cfg_idx,
  input logic              wr_fixed,
  input logic              wr_accept,
  input attr_t [NREG-1:0]  attr_q
);
  logic fixed_ok;
  always_comb begin
    fixed_ok = 1'b1;
    for (int i = 0; i < int'(NFIX); i++)
      if (attr_q[i] != 2'b01) fixed_ok = 1'b0;
  end

  logic [WORD_W-1:0] rsv_mask;
  assign rsv_mask = ~((WORD_W'(1) << CACHE_B) | (WORD_W'(1) << PREF_B));

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & rsv_mask) == '0); // R3

  AST_FIXED_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_ok); // R4

  AST_FIXED_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fixed |-> !wr_accept); // R4

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> attr_q[$past(cfg_idx)] ==
      {$past(cfg_wdata[PREF_B]), $past(cfg_wdata[CACHE_B])}); // R7

  AST_LOOKUP_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    {lk_prefetch, lk_cacheable} == attr_q[lk_addr[ADDR_W-1 -: IW]]); // R8

  AST_READ_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    {cfg_rdata[PREF_B], cfg_rdata[CACHE_B]} == attr_q[cfg_idx]); // R2
endmodule

bind rattr_regfile rattr_chk #(.NREG(NREG), .NFIX(NFIX)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .lk_addr(lk_addr), .lk_cacheable(lk_cacheable), .lk_prefetch(lk_prefetch),
  .cfg_idx(cfg_idx), .wr_fixed(wr_fixed), .wr_accept(wr_accept),
  .attr_q(attr_q)
);

// File: tb/sim_rattr_regfile.sv
`timescale 1ns/1ps
module sim_rattr_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_off = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] lk_addr = '0;
  logic        lk_cacheable;
  logic        lk_prefetch;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rattr_regfile u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_addr(lk_addr),
    .lk_cacheable(lk_cacheable), .lk_prefetch(lk_prefetch)
  );

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Expected word: only bits 0 and 3 survive.
  function automatic logic [31:0] keep(input logic [31:0] w);
    return w & 32'h0000_0009;
  endfunction

  task automatic wr(input logic [9:0] off, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_off = off; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] off, input logic [31:0] exp);
    cfg_off = off;
    #1;
    check32(req, cfg_rdata, exp);
  endtask

  task automatic lk_chk(input string req, input logic [31:0] a, input logic c, input logic p);
    lk_addr = a;
    #1;
    check32(req, {30'd0, lk_prefetch, lk_cacheable}, {30'd0, p, c});
  endtask

  task automatic t_reset;
    rd_chk("R4 reset fixed reg0", 10'h000, 32'h1);
    rd_chk("R4 reset fixed reg15", 10'h03C, 32'h1);
    rd_chk("R6 reset reg16", 10'h040, 32'h0);
    rd_chk("R6 reset reg255", 10'h3FC, 32'h0);
    lk_chk("R1 lookup fixed region", 32'h0C12_3456, 1'b1, 1'b0);
    lk_chk("R6 lookup writable region", 32'h8000_0000, 1'b0, 1'b0);
  endtask

  task automatic t_write_mask;
    // first writable word, all ones written
    wr(10'h040, 32'hFFFF_FFFF);
    rd_chk("R3 reserved bits zero", 10'h040, keep(32'hFFFF_FFFF));
    wr(10'h044, 32'hFFFF_FFF6);
    rd_chk("R3 no attr bits set", 10'h044, 32'h0);
  endtask

  task automatic t_fixed_ignored;
    wr(10'h030, 32'h0000_0008);
    rd_chk("R4 reg12 write ignored", 10'h030, 32'h1);
    lk_chk("R4 lookup reg12 unchanged", 32'h0CFF_FFFF, 1'b1, 1'b0);
    wr(10'h03C, 32'h0);
    rd_chk("R4 reg15 write ignored", 10'h03C, 32'h1);
  endtask

  task automatic t_timing;
    @(negedge clk);
    cfg_we = 1'b1; cfg_off = 10'h220; cfg_wdata = 32'h9;
    #1;
    check32("R7 not stored before edge", cfg_rdata, 32'h0);
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    check32("R7 stored after edge", cfg_rdata, 32'h9);
  endtask

  task automatic t_lookup;
    wr(10'h220, 32'h8);                  // region 0x88: prefetch only
    lk_chk("R2 prefetch-only region", 32'h8812_3456, 1'b0, 1'b1);
    wr(10'h224, 32'h1);                  // region 0x89: cacheable only
    lk_chk("R2 cacheable-only region", 32'h89AB_CDEF, 1'b1, 1'b0);
    lk_chk("R1 neighbour region 0x87", 32'h87FF_FFFF, 1'b0, 1'b0);
    lk_chk("R8 first writable region", 32'h1000_0000, 1'b1, 1'b1);
  endtask

  task automatic t_offset;
    wr(10'h0C3, 32'h9);                  // low bits ignored -> region 48
    rd_chk("R5 unaligned offset", 10'h0C0, 32'h9);
    lk_chk("R5 region 48 lookup", 32'h3000_0001, 1'b1, 1'b1);
    wr(10'h3FC, 32'h8);
    rd_chk("R5 last offset", 10'h3FF, 32'h8);
    lk_chk("R8 top region", 32'hFFFF_FFFF, 1'b0, 1'b1);
    rd_chk("R6 untouched region", 10'h3F8, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_mask();
    t_fixed_ignored();
    t_timing();
    t_lookup();
    t_offset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule